// File: doc/BRIEF.md
# AXI Read/Write Burst Splitter

This block turns one DMA transfer request into a series of AXI address-channel bursts. A request names a start byte address, a total beat count and a direction. The block cuts the transfer into bursts whose lengths follow a burst policy set on plain configuration pins, and issues them on the read address channel (AR) or the write address channel (AW). Beats are 4 bytes wide, addresses are 32 bits and every burst is of INCR type. The data payload is not moved here. The block only watches read-last beats and write responses, so that it knows how many bursts are still open in each direction.

The policy has two modes. In fixed mode a burst may be 1 beat long, or any of the enabled lengths 16, 8 and 4. In any-length mode a burst may be any length from 1 up to a programmed maximum. In both modes no burst may cross a 1 KB or a 4 KB address boundary, and address-aligned mode can also force each burst to start on a multiple of its own size. Each direction has its own outstanding limit N, and up to N+1 bursts may be open at once.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the request is finished, so back-pressure lasts for the whole transfer. AR and AW use the usual AXI rule: once valid is raised, it stays high and the address and length stay stable until ready is seen. The configuration pins must not change while a request is in progress. When every burst has been issued and every response has come back, `done` pulses for one cycle.

Top module: `axi_burst_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `ar_valid`, `aw_valid` and `done` are 0. `req_ready` is high only while no request is in progress, and it drops in the cycle after a request is accepted.
- R2: A read request issues bursts only on AR and a write request only on AW. Burst k starts at the request address plus 4 times the beats issued before it. The length field is the beat count minus 1, the burst field is 2'b01 (INCR), and the lengths add up to the requested beat count.
- R3: No burst crosses a 1 KB address boundary when `cfg_bound_1k` is 1, or a 4 KB boundary when it is 0.
- R4: With `cfg_any_len` at 0, each burst uses the largest length that fits the remaining beats, the distance to the boundary and the alignment rule. The candidates are 1 and those of 16, 8 and 4 whose enables (`cfg_en16`, `cfg_en8`, `cfg_en4`) are set.
- R5: With `cfg_any_len` at 1, each burst uses the largest length from 1 to the programmed maximum that fits the same constraints. The maximum is `cfg_max_len`, with 0 read as 1 and values above 16 read as 16. The three fixed-length enables have no effect in this mode.
- R6: With `cfg_aligned` at 1, every burst length is a power of two and the burst's start address is a multiple of 4 times its length.
- R7: `ar_valid` is never high while the number of open read bursts equals `cfg_rd_limit`+1. `aw_valid` follows the same rule with `cfg_wr_limit`. The block does reach that number of open bursts when responses are slow.
- R8: A read burst closes on a beat where `r_valid`, `r_ready` and `r_last` are all high. A beat with `r_last` low closes nothing. A write burst closes when `b_valid` and `b_ready` are both high. If a burst is issued and another closes in the same cycle, the open count stays the same.
- R9: While `ar_valid` (or `aw_valid`) is high and ready is low, valid stays high and the address and length stay unchanged in the next cycle.
- R10: `done` is a one-cycle pulse. It is raised once all bursts of the request have been issued and all of them have closed. `req_ready` is high in the cycle after it.
- R11: A request with a beat count of 0 issues no burst and still produces a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle; request accepted when both high |
| req_addr | input | 32 | Start byte address (4-byte aligned) |
| req_beats | input | 16 | Total number of beats |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| cfg_any_len | input | 1 | 1 = any length up to maximum, 0 = fixed lengths |
| cfg_max_len | input | 5 | Maximum length in any-length mode |
| cfg_en16 | input | 1 | Allow length 16 in fixed mode |
| cfg_en8 | input | 1 | Allow length 8 in fixed mode |
| cfg_en4 | input | 1 | Allow length 4 in fixed mode |
| cfg_bound_1k | input | 1 | 1 = 1 KB boundary, 0 = 4 KB boundary |
| cfg_aligned | input | 1 | Force bursts to start on their own size |
| cfg_rd_limit | input | 4 | Read outstanding limit (N+1 allowed) |
| cfg_wr_limit | input | 4 | Write outstanding limit (N+1 allowed) |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | 32 | Read burst address |
| ar_len | output | 8 | Read burst length minus 1 |
| ar_burst | output | 2 | Read burst type (INCR) |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | 32 | Write burst address |
| aw_len | output | 8 | Write burst length minus 1 |
| aw_burst | output | 2 | Write burst type (INCR) |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_last | input | 1 | Last beat of a read burst (observed) |
| b_valid | input | 1 | Write response valid (observed) |
| b_ready | input | 1 | Write response ready (observed) |
| done | output | 1 | One-cycle completion pulse |

## Verification
In the same cycle, the outstanding counter of one direction can be raised by a new address handshake and lowered by a closing response. This is what decides whether the next burst may leave and when `done` fires. The bench provokes it with a responder and address-ready stalls that change at random from cycle to cycle. It uses small limits and long transfers, so that issue and completion often land on the same edge while the counter is at its cap. The bench keeps its own open-burst count from the handshakes it sees. It judges the case by whether valid is ever raised at the cap, whether the cap is actually reached, and whether `done` arrives exactly when that count returns to zero.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } bs_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/bsplit_len_calc.sv
module bsplit_len_calc #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BURST  = 16,
  parameter int SMALL_BND  = 1024,
  parameter int LARGE_BND  = 4096,
  parameter int LEN_W      = $clog2(MAX_BURST + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  rem,
  input  logic              any_len,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              en_large,
  input  logic              en_mid,
  input  logic              en_small,
  input  logic              small_bnd,
  input  logic              aligned,
  output logic [LEN_W-1:0]  len
);

  localparam int SHIFT = $clog2(BEAT_BYTES);
  localparam int FIX_L = MAX_BURST;
  localparam int FIX_M = MAX_BURST / 2;
  localparam int FIX_S = MAX_BURST / 4;

  logic [ADDR_W-1:0] bnd, off, gap, cap, maxc, wa;
  logic              allow, pow2, algn_ok;
  int                best;

  // Pick the largest legal length by scanning upward.
  always_comb begin
    bnd  = small_bnd ? ADDR_W'(SMALL_BND) : ADDR_W'(LARGE_BND);
    off  = addr & (bnd - ADDR_W'(1));
    gap  = (bnd - off) >> SHIFT;
    cap  = (ADDR_W'(rem) < gap) ? ADDR_W'(rem) : gap;
    if (max_len == '0)
      maxc = ADDR_W'(1);
    else if (ADDR_W'(max_len) > ADDR_W'(MAX_BURST))
      maxc = ADDR_W'(MAX_BURST);
    else
      maxc = ADDR_W'(max_len);
    wa    = addr >> SHIFT;
    best  = 1;
    allow = 1'b0;
    pow2  = 1'b0;
    algn_ok = 1'b0;
    for (int l = 1; l <= MAX_BURST; l++) begin
      if (any_len)
        allow = (ADDR_W'(l) <= maxc);
      else
        allow = (l == 1) || (l == FIX_L && en_large) ||
                (l == FIX_M && en_mid) || (l == FIX_S && en_small);
      pow2    = ((l & (l - 1)) == 0);
      algn_ok = !aligned || (pow2 && ((wa & ADDR_W'(l - 1)) == '0));
      if (allow && algn_ok && (ADDR_W'(l) <= cap))
        best = l;
    end
    len = LEN_W'(best);
  end

endmodule

// File: rtl/bsplit_osr_ctr.sv
module bsplit_osr_ctr #(
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic [LIM_W-1:0] limit,
  output logic             room,
  output logic             idle
);

  logic [LIM_W:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign room = (cnt <= {1'b0, limit});
  assign idle = (cnt == '0);

  // R7: open count never passes limit+1
  a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= ({1'b0, limit} + 1'b1)));

  // R8: issue and close in one cycle leave the count alone
  a_r8_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/bsplit_seq.sv
module bsplit_seq
  import bsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int LEN_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              rd_room,
  input  logic              wr_room,
  input  logic              rd_idle,
  input  logic              wr_idle,
  input  logic              ar_ready,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_rem,
  output logic              ar_valid,
  output logic              aw_valid,
  output logic              ar_fire,
  output logic              aw_fire,
  output logic              done
);

  localparam int SHIFT = $clog2(BEAT_BYTES);

  bs_state_e state;
  logic      is_wr;
  logic      fire;

  assign req_ready = (state == ST_IDLE);
  assign ar_valid  = (state == ST_ISSUE) && !is_wr && rd_room;
  assign aw_valid  = (state == ST_ISSUE) &&  is_wr && wr_room;
  assign ar_fire   = ar_valid && ar_ready;
  assign aw_fire   = aw_valid && aw_ready;
  assign fire      = ar_fire || aw_fire;
  assign done      = (state == ST_DRAIN) && (is_wr ? wr_idle : rd_idle);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      cur_rem  <= '0;
      is_wr    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          cur_rem  <= req_beats;
          is_wr    <= req_write;
          state    <= (req_beats == '0) ? ST_DRAIN : ST_ISSUE;
        end
        ST_ISSUE: if (fire) begin
          cur_addr <= cur_addr + (ADDR_W'(burst_len) << SHIFT);
          cur_rem  <= cur_rem - CNT_W'(burst_len);
          if (cur_rem == CNT_W'(burst_len))
            state <= ST_DRAIN;
        end
        ST_DRAIN: if (done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: no address valid while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(ar_valid || aw_valid));

  // R10: done lasts one cycle and leaves the block idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R2: the two channels never compete
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(ar_valid && aw_valid));

endmodule

// File: rtl/axi_burst_splitter.sv
module axi_burst_splitter
  import bsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BURST  = 16,
  parameter int SMALL_BND  = 1024,
  parameter int LARGE_BND  = 4096,
  parameter int LIM_W      = 4,
  parameter int LEN_W      = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  input  logic              req_write,
  input  logic              cfg_any_len,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_en16,
  input  logic              cfg_en8,
  input  logic              cfg_en4,
  input  logic              cfg_bound_1k,
  input  logic              cfg_aligned,
  input  logic [LIM_W-1:0]  cfg_rd_limit,
  input  logic [LIM_W-1:0]  cfg_wr_limit,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [1:0]        ar_burst,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic [1:0]        aw_burst,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic              r_last,
  input  logic              b_valid,
  input  logic              b_ready,
  output logic              done
);

  localparam int SHIFT  = $clog2(BEAT_BYTES);
  localparam int SB_LO  = $clog2(SMALL_BND);
  localparam int LB_LO  = $clog2(LARGE_BND);

  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_rem;
  logic [LEN_W-1:0]  burst_len;
  logic rd_room, wr_room, rd_idle, wr_idle, ar_fire, aw_fire;
  logic rd_close, wr_close;

  assign rd_close = r_valid && r_ready && r_last;
  assign wr_close = b_valid && b_ready;

  bsplit_len_calc #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES),
    .MAX_BURST(MAX_BURST), .SMALL_BND(SMALL_BND), .LARGE_BND(LARGE_BND),
    .LEN_W(LEN_W)
  ) u_len (
    .addr(cur_addr), .rem(cur_rem), .any_len(cfg_any_len),
    .max_len(cfg_max_len), .en_large(cfg_en16), .en_mid(cfg_en8),
    .en_small(cfg_en4), .small_bnd(cfg_bound_1k), .aligned(cfg_aligned),
    .len(burst_len)
  );

  bsplit_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .req_write(req_write),
    .burst_len(burst_len), .rd_room(rd_room), .wr_room(wr_room),
    .rd_idle(rd_idle), .wr_idle(wr_idle), .ar_ready(ar_ready),
    .aw_ready(aw_ready), .cur_addr(cur_addr), .cur_rem(cur_rem),
    .ar_valid(ar_valid), .aw_valid(aw_valid), .ar_fire(ar_fire),
    .aw_fire(aw_fire), .done(done)
  );

  bsplit_osr_ctr #(.LIM_W(LIM_W)) u_rd_osr (
    .clk(clk), .rst_n(rst_n), .inc(ar_fire), .dec(rd_close),
    .limit(cfg_rd_limit), .room(rd_room), .idle(rd_idle)
  );

  bsplit_osr_ctr #(.LIM_W(LIM_W)) u_wr_osr (
    .clk(clk), .rst_n(rst_n), .inc(aw_fire), .dec(wr_close),
    .limit(cfg_wr_limit), .room(wr_room), .idle(wr_idle)
  );

  assign ar_addr  = cur_addr;
  assign aw_addr  = cur_addr;
  assign ar_len   = 8'(burst_len) - 8'd1;
  assign aw_len   = 8'(burst_len) - 8'd1;
  assign ar_burst = BURST_INCR;
  assign aw_burst = BURST_INCR;

  // Checking helpers
  logic [ADDR_W-1:0] last_byte;
  logic              same_page, len_pow2, start_algn;
  assign last_byte  = cur_addr + (ADDR_W'(burst_len) << SHIFT) - ADDR_W'(1);
  assign same_page  = cfg_bound_1k ?
                      (cur_addr[ADDR_W-1:SB_LO] == last_byte[ADDR_W-1:SB_LO]) :
                      (cur_addr[ADDR_W-1:LB_LO] == last_byte[ADDR_W-1:LB_LO]);
  assign len_pow2   = $countones(burst_len) == 1;
  assign start_algn = ((cur_addr >> SHIFT) & (ADDR_W'(burst_len) - ADDR_W'(1))) == '0;

  // R3: an issued burst stays inside one boundary window
  a_r3_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire || aw_fire) |-> same_page);

  // R6: aligned mode gives power-of-two, self-aligned bursts
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ((ar_fire || aw_fire) && cfg_aligned) |-> (len_pow2 && start_algn));

  // R9: read address held under back-pressure
  a_r9_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_len)));

  // R9: write address held under back-pressure
  a_r9_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr) && $stable(aw_len)));

  // R2: length field stays within the supported range
  a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid || aw_valid) |-> (burst_len != '0 && burst_len <= LEN_W'(MAX_BURST)));

endmodule

// File: tb/tb_axi_burst_splitter.sv
`timescale 1ns/1ps
module tb_axi_burst_splitter;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_beats = '0;
  logic        req_write = 1'b0;
  logic        cfg_any_len = 1'b0;
  logic [4:0]  cfg_max_len = '0;
  logic        cfg_en16 = 1'b0, cfg_en8 = 1'b0, cfg_en4 = 1'b0;
  logic        cfg_bound_1k = 1'b0, cfg_aligned = 1'b0;
  logic [3:0]  cfg_rd_limit = 4'd1, cfg_wr_limit = 4'd1;
  logic        ar_valid, aw_valid, done;
  logic        ar_ready = 1'b0, aw_ready = 1'b0;
  logic [31:0] ar_addr, aw_addr;
  logic [7:0]  ar_len, aw_len;
  logic [1:0]  ar_burst, aw_burst;
  logic        r_valid = 1'b0, r_ready = 1'b0, r_last = 1'b0;
  logic        b_valid = 1'b0, b_ready = 1'b0;

  axi_burst_splitter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .req_write(req_write),
    .cfg_any_len(cfg_any_len), .cfg_max_len(cfg_max_len),
    .cfg_en16(cfg_en16), .cfg_en8(cfg_en8), .cfg_en4(cfg_en4),
    .cfg_bound_1k(cfg_bound_1k), .cfg_aligned(cfg_aligned),
    .cfg_rd_limit(cfg_rd_limit), .cfg_wr_limit(cfg_wr_limit),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_burst(ar_burst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_burst(aw_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
    .b_valid(b_valid), .b_ready(b_ready), .done(done)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [7:0]  len;
    logic        wr;
  } exp_t;

  exp_t q[$];
  int   rq[$];
  int   b_pend = 0;
  int   checks = 0, errors = 0;
  int   rd_inf = 0, wr_inf = 0, rd_max = 0, wr_max = 0;
  int   done_cnt = 0, cyc = 0;
  bit   prev_done = 0, ar_hold = 0, aw_hold = 0;
  logic [31:0] hold_a = '0;
  logic [7:0]  hold_l = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit fits_align(input logic [31:0] a, input int l);
    if (!cfg_aligned) return 1'b1;
    return ((l & (l - 1)) == 0) && ((int'(a / 4) % l) == 0);
  endfunction

  // Independent model of the length rule (R3, R4, R5, R6)
  function automatic int model_len(input logic [31:0] a, input int rem);
    int bnd, gap, cap, m;
    int cand[4];
    bit en[4];
    bnd = cfg_bound_1k ? 1024 : 4096;
    gap = (bnd - int'(a % bnd)) / 4;
    cap = (rem < gap) ? rem : gap;
    if (cfg_any_len) begin
      m = (cfg_max_len == 0) ? 1 : ((cfg_max_len > 16) ? 16 : int'(cfg_max_len));
      for (int l = m; l >= 1; l--)
        if (l <= cap && fits_align(a, l)) return l;
      return 1;
    end
    cand[0] = 16; cand[1] = 8; cand[2] = 4; cand[3] = 1;
    en[0] = cfg_en16; en[1] = cfg_en8; en[2] = cfg_en4; en[3] = 1'b1;
    for (int i = 0; i < 4; i++)
      if (en[i] && cand[i] <= cap && fits_align(a, cand[i])) return cand[i];
    return 1;
  endfunction

  task automatic score(input bit wr, input logic [31:0] a, input logic [7:0] l,
                       input logic [1:0] bt, input int open_now, input int lim);
    exp_t e;
    int bnd, n;
    string tag;
    tag = cfg_any_len ? "R5" : "R4";
    chk(open_now <= lim, "R7", "open bursts at issue", open_now, lim);
    if (q.size() == 0) begin
      chk(0, "R2", "unexpected burst addr", int'(a), -1);
      return;
    end
    e = q.pop_front();
    chk(a == e.a, "R2", "burst address", int'(a), int'(e.a));
    chk(l == e.len, tag, "burst length field", int'(l), int'(e.len));
    chk(wr == e.wr, "R2", "burst channel", wr, e.wr);
    chk(bt == 2'b01, "R2", "burst type", bt, 1);
    n   = int'(l) + 1;
    bnd = cfg_bound_1k ? 1024 : 4096;
    chk((a / bnd) == ((a + n * 4 - 1) / bnd), "R3", "boundary crossed at addr",
        int'(a), -1);
    if (cfg_aligned)
      chk(((n & (n - 1)) == 0) && ((int'(a / 4) % n) == 0), "R6",
          "unaligned burst length", n, -1);
  endtask

  // Monitor, scoreboard and responder
  always @(negedge clk) begin
    int rd_now, wr_now;
    if (rst_n) begin
      cyc++;
      rd_now = rd_inf;
      wr_now = wr_inf;
      if (ar_valid && rd_now == int'(cfg_rd_limit) + 1)
        chk(0, "R7", "ar_valid at read cap", rd_now, int'(cfg_rd_limit));
      if (aw_valid && wr_now == int'(cfg_wr_limit) + 1)
        chk(0, "R7", "aw_valid at write cap", wr_now, int'(cfg_wr_limit));
      if (ar_hold)
        chk(ar_valid && ar_addr == hold_a && ar_len == hold_l, "R9",
            "AR changed under stall", int'(ar_addr), int'(hold_a));
      if (aw_hold)
        chk(aw_valid && aw_addr == hold_a && aw_len == hold_l, "R9",
            "AW changed under stall", int'(aw_addr), int'(hold_a));
      if (done) begin
        chk(!prev_done, "R10", "done longer than one cycle", 2, 1);
        chk(q.size() == 0 && rd_now == 0 && wr_now == 0, "R10",
            "done with work open", q.size() + rd_now + wr_now, 0);
        done_cnt++;
      end
      prev_done = done;

      // responses: R8 (non-last beats and stalls close nothing)
      r_ready = ($urandom % 4) != 0;
      b_ready = ($urandom % 4) != 0;
      r_valid = (rq.size() > 0) && (($urandom % 3) == 0);
      r_last  = r_valid && (rq[0] == 1);
      if (r_valid && r_ready) begin
        rq[0] = rq[0] - 1;
        if (rq[0] == 0) begin
          void'(rq.pop_front());
          rd_inf--;
        end
      end
      b_valid = (b_pend > 0) && (($urandom % 3) == 0);
      if (b_valid && b_ready) begin
        b_pend--;
        wr_inf--;
      end

      // address channels
      ar_ready = ($urandom % 4) != 0;
      aw_ready = ($urandom % 4) != 0;
      ar_hold  = ar_valid && !ar_ready;
      aw_hold  = aw_valid && !aw_ready;
      if (ar_valid) begin hold_a = ar_addr; hold_l = ar_len; end
      if (aw_valid) begin hold_a = aw_addr; hold_l = aw_len; end
      if (ar_valid && ar_ready) begin
        score(1'b0, ar_addr, ar_len, ar_burst, rd_now, int'(cfg_rd_limit));
        rd_inf++;
        if (rd_inf > rd_max) rd_max = rd_inf;
        rq.push_back(int'(ar_len) + 1);
      end
      if (aw_valid && aw_ready) begin
        score(1'b1, aw_addr, aw_len, aw_burst, wr_now, int'(cfg_wr_limit));
        wr_inf++;
        if (wr_inf > wr_max) wr_max = wr_inf;
        b_pend++;
      end

      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic set_cfg(input bit any, input int maxl, input bit e16,
                         input bit e8, input bit e4, input bit b1k,
                         input bit al, input int rl, input int wl);
    @(negedge clk);
    cfg_any_len  = any;
    cfg_max_len  = 5'(maxl);
    cfg_en16     = e16;
    cfg_en8      = e8;
    cfg_en4      = e4;
    cfg_bound_1k = b1k;
    cfg_aligned  = al;
    cfg_rd_limit = 4'(rl);
    cfg_wr_limit = 4'(wl);
  endtask

  // Driver: model the bursts, push them, then issue the request
  task automatic run_req(input logic [31:0] a, input int beats, input bit wr);
    int rem, l, d0;
    logic [31:0] p;
    exp_t e;
    rem = beats;
    p   = a;
    while (rem > 0) begin
      l     = model_len(p, rem);
      e.a   = p;
      e.len = 8'(l - 1);
      e.wr  = wr;
      q.push_back(e);
      p   = p + 32'(l * 4);
      rem = rem - l;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    d0        = done_cnt;
    req_addr  = a;
    req_beats = 16'(beats);
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "req_ready while busy", req_ready, 0);
    for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10", "done pulses for request", done_cnt - d0, 1);
    chk(q.size() == 0, "R2", "bursts still expected", q.size(), 0);
    @(negedge clk);
    chk(req_ready, "R10", "req_ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(ar_valid == 1'b0, "R1", "ar_valid after reset", ar_valid, 0);
    chk(aw_valid == 1'b0, "R1", "aw_valid after reset", aw_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);

    // R4 fixed lengths, all enabled
    set_cfg(0, 0, 1, 1, 1, 0, 0, 1, 1);
    run_req(32'h100, 37, 0);
    // R3 4 KB boundary with only 16 enabled
    set_cfg(0, 0, 1, 0, 0, 0, 0, 1, 1);
    run_req(32'hFF8, 20, 0);
    // R3 1 KB boundary, R5 any-length, write
    set_cfg(1, 16, 0, 0, 0, 1, 0, 1, 1);
    run_req(32'h3F0, 10, 1);
    // R5 fixed enables ignored, max 12
    set_cfg(1, 12, 0, 1, 1, 0, 0, 1, 1);
    run_req(32'h0, 30, 0);
    // R5 max 0 reads as 1
    set_cfg(1, 0, 1, 1, 1, 0, 0, 1, 1);
    run_req(32'h40, 3, 0);
    // R5 max above 16 reads as 16
    set_cfg(1, 31, 0, 0, 0, 0, 0, 1, 1);
    run_req(32'h2000, 40, 1);
    // R6 aligned fixed mode
    set_cfg(0, 0, 1, 1, 1, 0, 1, 1, 1);
    run_req(32'h14, 40, 0);
    // R6 aligned any-length mode
    set_cfg(1, 16, 0, 0, 0, 0, 1, 1, 1);
    run_req(32'h1C, 21, 1);
    // R7 write limit 0: one burst open at a time
    set_cfg(0, 0, 0, 0, 1, 0, 0, 1, 0);
    wr_max = 0;
    run_req(32'h200, 24, 1);
    chk(wr_max == 1, "R7", "peak open writes", wr_max, 1);
    // R7 / R8 read limit 3: cap reached, issue and close overlap
    set_cfg(1, 16, 0, 0, 0, 0, 0, 3, 1);
    rd_max = 0;
    run_req(32'h0, 200, 0);
    chk(rd_max == 4, "R7", "peak open reads", rd_max, 4);
    // R8 default limits with short bursts
    set_cfg(0, 0, 0, 0, 1, 1, 0, 1, 1);
    rd_max = 0;
    run_req(32'h3C0, 64, 0);
    chk(rd_max == 2, "R8", "peak open reads at default limit", rd_max, 2);
    // R11 zero beats
    set_cfg(0, 0, 1, 1, 1, 0, 0, 1, 1);
    run_req(32'h80, 0, 1);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule